// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a down-counting watchdog that runs from a slow, independent timebase, brought in as a one-cycle tick enable on the block clock. Software controls it through a 16-bit key port. One key starts the watchdog. One key refreshes the counter. One key opens the prescaler and reload registers for writing. Once the watchdog is started, nothing can stop it. If software fails to refresh it in time, the counter reaches zero and the block raises a one-clock reset request.

Each configuration register has two copies. The first is the written value, which reads back at once. The second is the value in effect, which the divider and the counter use. A write copies into the effective value only at the next boundary of the prescaled tick. Until that boundary, a per-register pending flag stays set and further writes to that register are blocked. A debug-freeze enable, combined with a debug-halt input, stops the whole timebase while the core is halted.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block shows: prescaler code 0, reload 4095, count 4095, watchdog stopped, configuration locked, both pending flags clear, reset request low.
- R2: A configuration write has no effect while locked. The block is locked after reset, after a refresh key, and after any key value other than 0x5555, 0xAAAA or 0xCCCC.
- R3: Writing key 0x5555 unlocks configuration. A write then stores the value, which reads back on the next cycle, and sets that register's pending flag. Pending bit 0 is the prescaler and bit 1 is the reload. cfg_sel_i selects the register: 0 for the prescaler (low 3 data bits), 1 for the reload (12 bits).
- R4: While a register's pending flag is set, further writes to that register are ignored.
- R5: A pending value takes effect, and its flag clears, at the next prescaled-tick boundary. The divider's first boundary after reset falls on the 4th tick.
- R6: The prescaled tick fires once every 1 << (code + 2) ticks of tick_i: 4, 8, 16, 32, 64, 128 or 256 for codes 0 to 6.
- R7: Key 0xCCCC starts a stopped watchdog. It loads the counter from the effective reload, restarts the divider at zero and raises active_o.
- R8: While running, the count drops by one at each prescaled tick. A prescaled tick that finds the count at 0 raises reset_req_o for exactly one clock. After that the counter stays at 0, and later keys have no effect on it.
- R9: Key 0xAAAA reloads a running counter from the effective reload and relocks configuration. It does not restart the divider.
- R10: Once started, the watchdog keeps active_o high. No key value stops it, and unrecognised keys leave the count unchanged.
- R11: When dbg_freeze_en_i and dbg_halt_i are both high, ticks are ignored and the count holds. With dbg_freeze_en_i low, a halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable from the slow timebase |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | 16 | Key value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the prescaler, 1 selects the reload |
| cfg_data_i | input | 12 | Configuration write data |
| dbg_halt_i | input | 1 | Core halted in debug |
| dbg_freeze_en_i | input | 1 | Freeze the timebase while halted |
| psc_o | output | 3 | Written prescaler code |
| rld_o | output | 12 | Written reload value |
| pend_o | output | 2 | Pending flags: bit 0 prescaler, bit 1 reload |
| count_o | output | 12 | Current count |
| active_o | output | 1 | Watchdog started |
| reset_req_o | output | 1 | One-clock reset request |

## Verification
Most internal faults in this block show up at the ports within one prescaled tick:
- A wrong divider limit moves the step of count_o by whole ticks.
- A lost lock state lets a blocked write appear on psc_o or rld_o on the next cycle.
- A stuck pending flag shows on pend_o right after the boundary that should clear it.

Faults in the expiry path show up later. The bench counts the reset-request pulses against the cycle the requirements predict. A missing pulse, a late pulse or a repeated pulse therefore shows up as a count or cycle mismatch.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  parameter int unsigned KEY_W = 16;
  parameter logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
  parameter logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  parameter logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

  typedef enum logic {
    CFG_PSC = 1'b0,
    CFG_RLD = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/wdt_key_dec.sv
module wdt_key_dec
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             start_o,
  output logic             refresh_o,
  output logic             unlocked_o
);
  logic unlock_hit, other_hit, unlocked_q;

  always_comb begin
    start_o    = key_we_i && (key_i == KEY_START);
    refresh_o  = key_we_i && (key_i == KEY_REFRESH);
    unlock_hit = key_we_i && (key_i == KEY_UNLOCK);
    other_hit  = key_we_i && !start_o && !refresh_o && !unlock_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     unlocked_q <= 1'b0;
    else if (unlock_hit)             unlocked_q <= 1'b1;
    else if (refresh_o || other_hit) unlocked_q <= 1'b0;
  end

  assign unlocked_o = unlocked_q;

  AST_REFRESH_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_o |=> !unlocked_o); // R9
  AST_STRAY_KEY_RELOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_i != KEY_UNLOCK && key_i != KEY_START) |=> !unlocked_o); // R2
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
#(
  parameter int unsigned PSC_W = 3,
  parameter int unsigned RLD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [RLD_W-1:0] data_i,
  input  logic             unlocked_i,
  input  logic             bnd_i,
  output logic [PSC_W-1:0] psc_wr_o,
  output logic [RLD_W-1:0] rld_wr_o,
  output logic [PSC_W-1:0] psc_act_o,
  output logic [RLD_W-1:0] rld_act_o,
  output logic [1:0]       pend_o
);
  logic [PSC_W-1:0] psc_wr_q, psc_act_q;
  logic [RLD_W-1:0] rld_wr_q, rld_act_q;
  logic [1:0]       pend_q;
  logic             psc_acc, rld_acc;

  assign psc_acc = we_i && unlocked_i && (sel_i == CFG_PSC) && !pend_q[0];
  assign rld_acc = we_i && unlocked_i && (sel_i == CFG_RLD) && !pend_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_wr_q  <= '0;
      psc_act_q <= '0;
      rld_wr_q  <= '1;
      rld_act_q <= '1;
      pend_q    <= '0;
    end else begin
      if (psc_acc) begin
        psc_wr_q  <= data_i[PSC_W-1:0];
        pend_q[0] <= 1'b1;
      end else if (bnd_i && pend_q[0]) begin
        psc_act_q <= psc_wr_q;
        pend_q[0] <= 1'b0;
      end
      if (rld_acc) begin
        rld_wr_q  <= data_i;
        pend_q[1] <= 1'b1;
      end else if (bnd_i && pend_q[1]) begin
        rld_act_q <= rld_wr_q;
        pend_q[1] <= 1'b0;
      end
    end
  end

  assign psc_wr_o  = psc_wr_q;
  assign rld_wr_o  = rld_wr_q;
  assign psc_act_o = psc_act_q;
  assign rld_act_o = rld_act_q;
  assign pend_o    = pend_q;

  AST_PSC_HELD_WHILE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[0] |=> $stable(psc_wr_q)); // R4
  AST_RLD_HELD_WHILE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q[1] |=> $stable(rld_wr_q)); // R4
  AST_LOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> ($stable(psc_wr_q) && $stable(rld_wr_q))); // R2
  AST_ACT_ONLY_AT_BND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> ($stable(psc_act_q) && $stable(rld_act_q))); // R5
endmodule

// File: rtl/wdt_div.sv
module wdt_div #(
  parameter int unsigned PSC_W    = 3,
  parameter int unsigned CODE_MAX = 6,
  localparam int unsigned DIV_W   = CODE_MAX + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             frozen_i,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             bnd_o
);
  logic [DIV_W-1:0] div_q, lim;
  logic [DIV_W:0]   span;
  logic [PSC_W-1:0] code;
  logic             adv;

  always_comb begin
    code = (psc_i > PSC_W'(CODE_MAX)) ? PSC_W'(CODE_MAX) : psc_i;
    span = (DIV_W+1)'(1) << (32'(code) + 32'd2);
    lim  = DIV_W'(span - 1'b1);
    adv  = tick_i && !frozen_i;
    bnd_o = adv && (div_q == lim) && !clear_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (clear_i)  div_q <= '0;
    else if (adv)      div_q <= (div_q == lim) ? '0 : div_q + 1'b1;
  end

  AST_FROZEN_NO_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_i |=> ($past(frozen_i) && !clear_i) -> $stable(div_q)); // R11
  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= lim); // R6
endmodule

// File: rtl/wdt_cnt.sv
module wdt_cnt #(
  parameter int unsigned RLD_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             refresh_i,
  input  logic             bnd_i,
  input  logic [RLD_W-1:0] rld_i,
  output logic             start_go_o,
  output logic [RLD_W-1:0] count_o,
  output logic             active_o,
  output logic             fire_o
);
  logic [RLD_W-1:0] cnt_q;
  logic             active_q, expired_q, fire_q;

  assign start_go_o = start_i && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      active_q  <= 1'b0;
      expired_q <= 1'b0;
      fire_q    <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (expired_q) begin
        cnt_q <= cnt_q;
      end else if (start_go_o) begin
        active_q <= 1'b1;
        cnt_q    <= rld_i;
      end else if (active_q && refresh_i) begin
        cnt_q <= rld_i;
      end else if (active_q && bnd_i) begin
        if (cnt_q == '0) begin
          expired_q <= 1'b1;
          fire_q    <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign count_o  = cnt_q;
  assign active_o = active_q;
  assign fire_o   = fire_q;

  AST_REQ_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |=> !fire_q); // R8
  AST_NO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |=> active_q); // R10
  AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !bnd_i && !refresh_i) |=> $stable(cnt_q)); // R8
  AST_EXPIRED_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> (cnt_q == '0)); // R8
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned PSC_W    = 3,
  parameter int unsigned RLD_W    = 12,
  parameter int unsigned CODE_MAX = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [RLD_W-1:0] cfg_data_i,
  input  logic             dbg_halt_i,
  input  logic             dbg_freeze_en_i,
  output logic [PSC_W-1:0] psc_o,
  output logic [RLD_W-1:0] rld_o,
  output logic [1:0]       pend_o,
  output logic [RLD_W-1:0] count_o,
  output logic             active_o,
  output logic             reset_req_o
);
  logic             start_p, refresh_p, unlocked, bnd, start_go, frozen;
  logic [PSC_W-1:0] psc_act;
  logic [RLD_W-1:0] rld_act;

  assign frozen = dbg_freeze_en_i && dbg_halt_i;

  wdt_key_dec u_key (
    .clk_i, .rst_ni, .key_we_i, .key_i,
    .start_o(start_p), .refresh_o(refresh_p), .unlocked_o(unlocked)
  );

  wdt_cfg #(.PSC_W(PSC_W), .RLD_W(RLD_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .data_i(cfg_data_i),
    .unlocked_i(unlocked), .bnd_i(bnd),
    .psc_wr_o(psc_o), .rld_wr_o(rld_o),
    .psc_act_o(psc_act), .rld_act_o(rld_act), .pend_o(pend_o)
  );

  wdt_div #(.PSC_W(PSC_W), .CODE_MAX(CODE_MAX)) u_div (
    .clk_i, .rst_ni, .tick_i, .frozen_i(frozen),
    .clear_i(start_go), .psc_i(psc_act), .bnd_o(bnd)
  );

  wdt_cnt #(.RLD_W(RLD_W)) u_cnt (
    .clk_i, .rst_ni,
    .start_i(start_p), .refresh_i(refresh_p), .bnd_i(bnd), .rld_i(rld_act),
    .start_go_o(start_go), .count_o(count_o), .active_o(active_o),
    .fire_o(reset_req_o)
  );

  AST_FREEZE_HOLDS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && !key_we_i) |=> $stable(count_o)); // R11
endmodule

// File: tb/keyed_watchdog_test.sv
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        key_we_i = 1'b0;
  logic [15:0] key_i = '0;
  logic        cfg_we_i = 1'b0;
  logic        cfg_sel_i = 1'b0;
  logic [11:0] cfg_data_i = '0;
  logic        dbg_halt_i = 1'b0;
  logic        dbg_freeze_en_i = 1'b0;
  logic [2:0]  psc_o;
  logic [11:0] rld_o, count_o;
  logic [1:0]  pend_o;
  logic        active_o, reset_req_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fires = 0;
  bit done = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  keyed_watchdog uut (
    .clk_i(clk), .rst_ni, .tick_i, .key_we_i, .key_i, .cfg_we_i, .cfg_sel_i,
    .cfg_data_i, .dbg_halt_i, .dbg_freeze_en_i, .psc_o, .rld_o, .pend_o,
    .count_o, .active_o, .reset_req_o
  );

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every reset request must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_ni && reset_req_o) begin
      fires++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: unexpected reset request at cycle %0d (expected none)", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R8: reset request at cycle %0d, expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
    end
    tick_i = 1'b0;
  endtask

  task automatic key(logic [15:0] v);
    key_we_i = 1'b1; key_i = v;
    @(negedge clk);
    key_we_i = 1'b0;
  endtask

  task automatic cfg(logic sel, logic [11:0] v);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_data_i = v;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish (expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 active", active_o, 0);
    check("R1 req", reset_req_o, 0);
    check("R1 psc", psc_o, 0);
    check("R1 rld", rld_o, 4095);
    check("R1 pend", pend_o, 0);
    check("R1 count", count_o, 4095);

    cfg(1'b1, 12'd5);
    check("R2 locked write", rld_o, 4095);
    key(16'h5555);
    cfg(1'b1, 12'd5);
    check("R3 rld readback", rld_o, 5);
    check("R3 pend reload", pend_o, 2);
    cfg(1'b1, 12'd9);
    check("R4 write while pending", rld_o, 5);
    ticks(4);
    check("R5 pend cleared", pend_o, 0);
    key(16'hAAAA);
    cfg(1'b1, 12'd7);
    check("R9 relock", rld_o, 5);

    key(16'hCCCC);
    check("R7 active", active_o, 1);
    check("R7 count load", count_o, 5);
    dbg_freeze_en_i = 1'b1; dbg_halt_i = 1'b1;
    ticks(8);
    check("R11 frozen count", count_o, 5);
    dbg_halt_i = 1'b0;
    ticks(10);
    check("R8 decrement", count_o, 3);
    dbg_freeze_en_i = 1'b0; dbg_halt_i = 1'b1;
    ticks(2);
    check("R11 halt without freeze", count_o, 2);
    dbg_halt_i = 1'b0;
    key(16'h0000);
    key(16'h1234);
    check("R10 still active", active_o, 1);
    check("R10 count untouched", count_o, 2);
    key(16'hAAAA);
    check("R9 refresh reload", count_o, 5);
    ticks(23);
    check("R8 count at zero", count_o, 0);
    check("R8 no early request", reset_req_o, 0);
    exp_q.push_back(cyc + 1);
    ticks(1);
    check("R8 request raised", reset_req_o, 1);
    @(negedge clk);
    check("R8 request one clock", reset_req_o, 0);
    ticks(8);
    key(16'hAAAA);
    key(16'hCCCC);
    check("R8 stays expired", count_o, 0);
    check("R8 no second request", fires, 1);
    check("R8 queue drained", exp_q.size(), 0);

    // divider 8
    do_reset();
    key(16'h5555);
    cfg(1'b0, 12'd1);
    cfg(1'b1, 12'd2);
    ticks(3);
    check("R5 still pending", pend_o, 3);
    ticks(1);
    check("R5 both applied", pend_o, 0);
    key(16'hCCCC);
    check("R7 load 2", count_o, 2);
    ticks(7);
    check("R6 code1 before boundary", count_o, 2);
    ticks(1);
    check("R6 code1 boundary", count_o, 1);

    // divider 256
    do_reset();
    key(16'h5555);
    cfg(1'b0, 12'd6);
    cfg(1'b1, 12'd1);
    cfg(1'b0, 12'd2);
    check("R4 psc while pending", psc_o, 6);
    ticks(4);
    check("R5 applied code6", pend_o, 0);
    key(16'h1111);
    cfg(1'b1, 12'd7);
    check("R2 stray key relocks", rld_o, 1);
    key(16'hCCCC);
    ticks(255);
    check("R6 code6 before boundary", count_o, 1);
    ticks(1);
    check("R6 code6 boundary", count_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule